// File: doc/BRIEF.md
# Pulse-Width Addressed Shunt Controller

This block listens to one shared command line on which every bit is sent as a single high pulse, and the length of the pulse gives the bit's value. Five bits make a command: four address bits, most significant first, then one data bit. Several copies of the block can hang on the same line, each with its own strapped address. Only the copy whose address matches the command acts on it. A data bit of 1 asserts the shunt output, which bypasses the local load. A data bit of 0 releases the shunt.

The pulse line and the over-voltage flag are asynchronous, so each one passes through a synchronizer clocked by the sampling clock. The block measures every pulse in sampling-clock cycles. Pulses that are too short or too long, and idle gaps that last too long, throw away a partly received frame. This lets the next pulse start a clean frame. A separate over-voltage flag latches a shutdown that holds the shunt asserted, and no command can release it. Only a power-on reset clears it. The analog level detection that produces the digital pulse line lies outside this block.

All timing limits are given as parameters in picoseconds, together with the sampling-clock period, and the block turns them into cycle counts. With the default 20 ns period the limits are as follows:
- The shortest legal pulse is 2 cycles.
- A pulse of 5 cycles or more decodes as a 1.
- The longest legal pulse is 12 cycles.
- An idle gap of 51 cycles clears a partial frame.

Top module: `pw_shunt_ctrl`

## Requirements
- R1: While `porN` is low and right after it rises, `shuntOn` and `ovTripped` are 0 and no partial frame is held, so the first five pulses after reset form a complete frame.
- R2: A pulse that stays high for 2 to 4 samples decodes as bit 0, and a pulse that stays high for 5 to 12 samples decodes as bit 1 (default 20 ns clock).
- R3: A pulse of 1 sample, or of 13 samples or more, is a framing error. It discards the bits already gathered for the current frame and is not counted as a bit.
- R4: A frame is 4 address bits sent most significant bit first, followed by 1 data bit. When the address equals `localAddr`, a data bit of 1 sets `shuntOn` and a data bit of 0 clears it.
- R5: A complete frame whose address differs from `localAddr` leaves `shuntOn` unchanged.
- R6: After 51 consecutive low samples of the synchronized line, any partial frame is discarded. A gap shorter than that keeps the partial frame.
- R7: A high sample of `ovFlag` sets `ovTripped`. From then on `shuntOn` is held at 1 and stays at 1 through any command, until `porN` goes low.
- R8: `shuntOn` takes the new value on the second rising edge after the edge that first samples the line low at the end of the data pulse. `ovTripped` rises on the second rising edge after the edge that first samples `ovFlag` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| pulseIn | input | 1 | Digitised pulse-width command line, asynchronous |
| localAddr | input | ADDR_W (4) | Strapped address of this unit |
| ovFlag | input | 1 | Over-voltage detect, asynchronous, active high |
| shuntOn | output | 1 | 1 = short (bypass) the load |
| ovTripped | output | 1 | Latched over-voltage shutdown status |

## Verification
The assertions assume that `localAddr` is static while a frame is in flight. They also assume that every pulse and gap on `pulseIn` lasts whole sampling-clock cycles, so the synchronizer never sees a glitch narrower than one cycle. The stimulus changes `pulseIn`, `ovFlag` and `localAddr` only on the falling clock edge, and it changes the address only between frames. The pulse lengths it sends sit right at each decode limit, on both sides (1, 2, 4, 5, 12 and 13 samples). It also sends idle gaps well below and well above the clear limit, and it interrupts partial frames in ways that would decode to a different address if the partial frame were not discarded.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

  // Classification of one completed pulse on the command line.
  typedef enum logic [1:0] {
    PC_NONE = 2'd0,
    PC_ZERO = 2'd1,
    PC_ONE  = 2'd2,
    PC_BAD  = 2'd3
  } pulseKind_e;

  // Strobes from the frame control to the datapath.
  typedef struct packed {
    logic shiftEn;  // push bitVal into the address shifter
    logic bitVal;   // decoded value of the current pulse
    logic commit;   // current pulse is the data bit of a full frame
  } ctrlStrobe_t;

endpackage

// File: rtl/spc_sync.sv
`timescale 1ns/1ps
module spc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= 1'b0;
        else       stage <= d;
      end
      assign q = stage;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spc_datapath.sv
`timescale 1ns/1ps
module spc_datapath
  import spc_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HI_SAT      = 13,
  parameter int HI_W        = 4,
  parameter int IDLE_CYC    = 51,
  parameter int LO_W        = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              ovFlag,
  input  logic [ADDR_W-1:0] localAddr,
  input  ctrlStrobe_t       strb,
  output logic              pulseEnd,
  output logic [HI_W-1:0]   pulseLen,
  output logic              idleHit,
  output logic              shuntOn,
  output logic              ovTripped
);

  localparam logic [HI_W-1:0] HI_TOP   = HI_W'(HI_SAT);
  localparam logic [LO_W-1:0] LO_TOP   = LO_W'(IDLE_CYC);
  localparam logic [LO_W-1:0] LO_FIRE  = LO_W'(IDLE_CYC - 1);

  logic              lineS;
  logic              ovS;
  logic              prevLine;
  logic [HI_W-1:0]   highCnt;
  logic [LO_W-1:0]   lowCnt;
  logic [ADDR_W-1:0] addrShift;
  logic              shuntReg;
  logic              ovLatched;

  spc_sync #(.STAGES(SYNC_STAGES)) i_syncLine (
    .clk (clk),
    .rstN(rstN),
    .d   (pulseIn),
    .q   (lineS)
  );

  spc_sync #(.STAGES(SYNC_STAGES)) i_syncOv (
    .clk (clk),
    .rstN(rstN),
    .d   (ovFlag),
    .q   (ovS)
  );

  // Pulse and gap measurement on the synchronized line.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLine <= 1'b0;
      highCnt  <= '0;
      lowCnt   <= '0;
    end else begin
      prevLine <= lineS;
      if (lineS) begin
        lowCnt  <= '0;
        if (highCnt != HI_TOP) highCnt <= highCnt + 1'b1;
      end else begin
        highCnt <= '0;
        if (lowCnt != LO_TOP) lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign pulseEnd = prevLine & ~lineS;
  assign pulseLen = highCnt;
  assign idleHit  = ~lineS & (lowCnt == LO_FIRE);

  // Address gathering, most significant bit arrives first.
  generate
    if (ADDR_W == 1) begin : g_addr1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             addrShift <= '0;
        else if (strb.shiftEn) addrShift <= strb.bitVal;
      end
    end else begin : g_addrN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             addrShift <= '0;
        else if (strb.shiftEn) addrShift <= {addrShift[ADDR_W-2:0], strb.bitVal};
      end
    end
  endgenerate

  // Shunt state and latched over-voltage shutdown.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shuntReg  <= 1'b0;
      ovLatched <= 1'b0;
    end else begin
      ovLatched <= ovLatched | ovS;
      if (strb.commit && (addrShift == localAddr)) shuntReg <= strb.bitVal;
    end
  end

  assign shuntOn   = shuntReg | ovLatched;
  assign ovTripped = ovLatched;

endmodule

// File: rtl/spc_control.sv
`timescale 1ns/1ps
module spc_control
  import spc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int HI_W    = 4,
  parameter int MIN_CYC = 2,
  parameter int ONE_CYC = 5,
  parameter int MAX_CYC = 12
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            pulseEnd,
  input  logic [HI_W-1:0] pulseLen,
  input  logic            idleHit,
  output ctrlStrobe_t     strb
);

  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_W);
  localparam logic [HI_W-1:0]  LEN_MIN  = HI_W'(MIN_CYC);
  localparam logic [HI_W-1:0]  LEN_ONE  = HI_W'(ONE_CYC);
  localparam logic [HI_W-1:0]  LEN_MAX  = HI_W'(MAX_CYC);

  pulseKind_e       kind;
  logic             goodBit;
  logic [CNT_W-1:0] bitPos;

  always_comb begin
    kind = PC_NONE;
    if (pulseEnd) begin
      if (pulseLen < LEN_MIN || pulseLen > LEN_MAX) kind = PC_BAD;
      else if (pulseLen >= LEN_ONE)                 kind = PC_ONE;
      else                                          kind = PC_ZERO;
    end
  end

  assign goodBit = (kind == PC_ZERO) || (kind == PC_ONE);

  always_comb begin
    strb.bitVal  = (kind == PC_ONE);
    strb.shiftEn = goodBit && (bitPos != LAST_POS);
    strb.commit  = goodBit && (bitPos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitPos <= '0;
    end else if (kind == PC_BAD || idleHit) begin
      bitPos <= '0;
    end else if (goodBit) begin
      bitPos <= (bitPos == LAST_POS) ? '0 : bitPos + 1'b1;
    end
  end

endmodule

// File: rtl/pw_shunt_ctrl.sv
`timescale 1ns/1ps
module pw_shunt_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int MIN_PULSE_PS  = 25000,
  parameter int ONE_PULSE_PS  = 100000,
  parameter int MAX_PULSE_PS  = 250000,
  parameter int IDLE_GAP_PS   = 1000000
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              pulseIn,
  input  logic [ADDR_W-1:0] localAddr,
  input  logic              ovFlag,
  output logic              shuntOn,
  output logic              ovTripped
);

  localparam int MIN_CYC  = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ONE_CYC  = (ONE_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int MAX_CYC  = MAX_PULSE_PS / CLK_PERIOD_PS;
  localparam int IDLE_CYC = IDLE_GAP_PS / CLK_PERIOD_PS + 1;
  localparam int HI_SAT   = MAX_CYC + 1;
  localparam int HI_W     = $clog2(HI_SAT + 1);
  localparam int LO_W     = $clog2(IDLE_CYC + 1);

  ctrlStrobe_t     strb;
  logic            pulseEnd;
  logic [HI_W-1:0] pulseLen;
  logic            idleHit;

  spc_datapath #(
    .ADDR_W     (ADDR_W),
    .SYNC_STAGES(SYNC_STAGES),
    .HI_SAT     (HI_SAT),
    .HI_W       (HI_W),
    .IDLE_CYC   (IDLE_CYC),
    .LO_W       (LO_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (porN),
    .pulseIn  (pulseIn),
    .ovFlag   (ovFlag),
    .localAddr(localAddr),
    .strb     (strb),
    .pulseEnd (pulseEnd),
    .pulseLen (pulseLen),
    .idleHit  (idleHit),
    .shuntOn  (shuntOn),
    .ovTripped(ovTripped)
  );

  spc_control #(
    .ADDR_W (ADDR_W),
    .HI_W   (HI_W),
    .MIN_CYC(MIN_CYC),
    .ONE_CYC(ONE_CYC),
    .MAX_CYC(MAX_CYC)
  ) i_ctl (
    .clk     (clk),
    .rstN    (porN),
    .pulseEnd(pulseEnd),
    .pulseLen(pulseLen),
    .idleHit (idleHit),
    .strb    (strb)
  );

endmodule

// File: rtl/pw_shunt_ctrl_chk.sv
`timescale 1ns/1ps
module pw_shunt_ctrl_chk #(
  parameter int HI_W    = 4,
  parameter int MIN_CYC = 2,
  parameter int MAX_CYC = 12
) (
  input logic            clk,
  input logic            porN,
  input logic            pulseEnd,
  input logic [HI_W-1:0] pulseLen,
  input logic            commit,
  input logic            shiftEn,
  input logic            shuntOn,
  input logic            ovTripped
);

  localparam logic [HI_W-1:0] LEN_MIN = HI_W'(MIN_CYC);
  localparam logic [HI_W-1:0] LEN_MAX = HI_W'(MAX_CYC);

  a_r7_ov_sticky: assert property (@(posedge clk) disable iff (!porN)
    ovTripped |=> ovTripped);

  a_r7_ov_forces_short: assert property (@(posedge clk) disable iff (!porN)
    ovTripped |-> shuntOn);

  a_r5_hold_without_commit: assert property (@(posedge clk) disable iff (!porN)
    !commit |=> (shuntOn == $past(shuntOn)) || ovTripped);

  a_r3_bad_len_ignored: assert property (@(posedge clk) disable iff (!porN)
    (pulseEnd && (pulseLen < LEN_MIN || pulseLen > LEN_MAX)) |-> (!commit && !shiftEn));

  a_r2_strobe_needs_pulse: assert property (@(posedge clk) disable iff (!porN)
    (commit || shiftEn) |-> pulseEnd);

  a_r4_commit_not_shift: assert property (@(posedge clk) disable iff (!porN)
    commit |-> !shiftEn);

endmodule

bind pw_shunt_ctrl pw_shunt_ctrl_chk #(
  .HI_W   (HI_W),
  .MIN_CYC(MIN_CYC),
  .MAX_CYC(MAX_CYC)
) u_chk (
  .clk      (clk),
  .porN     (porN),
  .pulseEnd (pulseEnd),
  .pulseLen (pulseLen),
  .commit   (strb.commit),
  .shiftEn  (strb.shiftEn),
  .shuntOn  (shuntOn),
  .ovTripped(ovTripped)
);

// File: tb/test_pw_shunt_ctrl.sv
`timescale 1ns/1ps
module test_pw_shunt_ctrl;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       pulseIn = 1'b0;
  logic [3:0] localAddr = 4'hA;
  logic       ovFlag = 1'b0;
  logic       shuntOn;
  logic       ovTripped;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;
  string curReq = "R1";

  always #10 clk = ~clk;  // 50 MHz

  pw_shunt_ctrl i_pw_shunt_ctrl (
    .clk      (clk),
    .porN     (porN),
    .pulseIn  (pulseIn),
    .localAddr(localAddr),
    .ovFlag   (ovFlag),
    .shuntOn  (shuntOn),
    .ovTripped(ovTripped)
  );

  // Limits in samples for a 20 ns clock, taken from the requirements.
  localparam int LMIN = 2, LONE = 5, LMAX = 12, LIDLE = 51;

  // Behavioural reference: two-sample delay line, run lengths, bit list.
  logic p0, p1, o0, o1, prevM, shM, ovM;
  int   runHi, runLo;
  int   bitsQ[$];

  always @(posedge clk) begin
    if (!porN) begin
      p0 = 0; p1 = 0; o0 = 0; o1 = 0; prevM = 0; shM = 0; ovM = 0;
      runHi = 0; runLo = 0; bitsQ.delete();
    end else begin
      if (p1) begin
        runHi++; runLo = 0;
      end else begin
        if (prevM) begin
          if (runHi < LMIN || runHi > LMAX) bitsQ.delete();
          else begin
            bitsQ.push_back(runHi >= LONE ? 1 : 0);
            if (bitsQ.size() == 5) begin
              int a;
              a = bitsQ[0] * 8 + bitsQ[1] * 4 + bitsQ[2] * 2 + bitsQ[3];
              if (a == int'(localAddr)) shM = bitsQ[4][0];
              bitsQ.delete();
            end
          end
        end
        runHi = 0;
        runLo++;
        if (runLo == LIDLE) bitsQ.delete();
      end
      if (o1) ovM = 1;
      prevM = p1;
      p1 = p0; p0 = pulseIn;
      o1 = o0; o0 = ovFlag;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (porN && !finished) begin
      nCmp++;
      if (shuntOn !== (shM | ovM) || ovTripped !== ovM) begin
        nBad++;
        $display("FAIL %s cycle compare: shuntOn=%b ovTripped=%b expected %b %b",
                 curReq, shuntOn, ovTripped, shM | ovM, ovM);
      end
    end
  end

  task automatic check(input string req, input logic expSh, input logic expOv);
    nCmp++;
    if (shuntOn !== expSh || ovTripped !== expOv) begin
      nBad++;
      $display("FAIL %s: shuntOn=%b ovTripped=%b expected %b %b",
               req, shuntOn, ovTripped, expSh, expOv);
    end
  endtask

  task automatic pulse(input int len, input int gap);
    @(negedge clk) pulseIn = 1'b1;
    repeat (len) @(negedge clk);
    pulseIn = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame(input logic [3:0] a, input logic d, input int nl, input int wl);
    for (int i = 3; i >= 0; i--) pulse(a[i] ? wl : nl, 4);
    pulse(d ? wl : nl, 10);
  endtask

  task automatic doReset();
    @(negedge clk) porN = 1'b0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nBad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 in reset", 1'b0, 1'b0);
    porN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 1'b0, 1'b0);

    // R1: partial frame cut by reset must not survive.
    pulse(7, 4); pulse(7, 4);
    doReset();
    frame(4'hA, 1'b1, 3, 7);
    check("R1 clean frame after reset", 1'b1, 1'b0);

    curReq = "R4";
    frame(4'hA, 1'b0, 3, 7);
    check("R4 release", 1'b0, 1'b0);
    frame(4'hA, 1'b1, 3, 7);
    check("R4 short", 1'b1, 1'b0);

    curReq = "R2";
    frame(4'hA, 1'b0, 2, 12);
    check("R2 lengths 2/12 release", 1'b0, 1'b0);
    frame(4'hA, 1'b1, 4, 5);
    check("R2 lengths 4/5 short", 1'b1, 1'b0);

    curReq = "R5";
    frame(4'h5, 1'b0, 3, 7);
    check("R5 other address no release", 1'b1, 1'b0);
    localAddr = 4'h0;
    frame(4'hF, 1'b0, 3, 7);
    check("R5 addr F vs 0 no change", 1'b1, 1'b0);
    frame(4'h0, 1'b0, 3, 7);
    check("R4 addr 0 release", 1'b0, 1'b0);
    localAddr = 4'hF;
    frame(4'hF, 1'b1, 3, 7);
    check("R4 addr F short", 1'b1, 1'b0);
    frame(4'hF, 1'b0, 3, 7);
    localAddr = 4'hA;

    curReq = "R3";
    pulse(7, 4); pulse(7, 4); pulse(1, 4);
    frame(4'hA, 1'b1, 3, 7);
    check("R3 1-sample pulse drops partial", 1'b1, 1'b0);
    frame(4'hA, 1'b0, 3, 7);
    pulse(7, 4); pulse(7, 4); pulse(13, 4);
    frame(4'hA, 1'b1, 3, 7);
    check("R3 13-sample pulse drops partial", 1'b1, 1'b0);
    frame(4'hA, 1'b0, 3, 7);

    curReq = "R6";
    pulse(7, 4); pulse(7, 80);
    frame(4'hA, 1'b1, 3, 7);
    check("R6 long gap drops partial", 1'b1, 1'b0);
    frame(4'hA, 1'b0, 3, 7);
    pulse(7, 4); pulse(7, 30);
    frame(4'hA, 1'b1, 3, 7);
    check("R6 short gap keeps partial", 1'b0, 1'b0);
    repeat (80) @(negedge clk);

    // R8: latency from last falling sample of the data pulse.
    curReq = "R8";
    for (int i = 3; i >= 0; i--) pulse(localAddr[i] ? 7 : 3, 4);
    @(negedge clk) pulseIn = 1'b1;
    repeat (7) @(negedge clk);
    pulseIn = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 not yet updated", 1'b0, 1'b0);
    @(negedge clk);
    check("R8 updated", 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    frame(4'hA, 1'b0, 3, 7);

    curReq = "R7";
    @(negedge clk) ovFlag = 1'b1;
    @(negedge clk) ovFlag = 1'b0;
    @(negedge clk);
    check("R7 not yet tripped", 1'b0, 1'b0);
    @(negedge clk);
    check("R7 tripped", 1'b1, 1'b1);
    frame(4'hA, 1'b0, 3, 7);
    check("R7 unshort overridden", 1'b1, 1'b1);
    doReset();
    @(negedge clk);
    check("R7 cleared by reset", 1'b0, 1'b0);
    frame(4'hA, 1'b1, 3, 7);
    check("R4 works after trip reset", 1'b1, 1'b0);

    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule